// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block tells an out-of-order core which earlier store a memory instruction should wait behind. Loads and stores that have collided in the past are grouped into a "set". A first table, indexed by bits of the instruction PC, maps each instruction to a set number. A second table, indexed by set number, remembers the sequence number of the most recently fetched store of that set that has not yet issued. Each set also has a population count.

Training happens on a reported ordering violation (a store PC and a load PC pair), which merges the two instructions into a common set. At fetch, a store that belongs to a set records its sequence number for that set. A combinational lookup turns a PC into a dependence tag: zero means "no dependence", any other value is the sequence number of the store to wait for. An issuing store retires its own record, and a squash drops records for the discarded younger instructions in a single cycle.

Top module: `ssp_predictor`

## Requirements
- R1: After reset every PC-table entry and every set record is invalid, so the lookup returns 0 for any PC.
- R2: The lookup is combinational on the registered state and returns 0 when the PC's table entry is invalid or its set's record is invalid; otherwise it returns the recorded sequence number.
- R3: A violation in which neither the store nor the load has a valid entry gives both the newly formed set number and adds one to that set's population.
- R4: A violation in which only the load has a valid entry places the store in the load's set and adds one to that set's population.
- R5: A violation in which only the store has a valid entry places the load in the store's set and leaves every population unchanged.
- R6: A violation in which both are valid compares populations: if the load's set is strictly larger the store moves into it, otherwise (ties included) the load moves into the store's set; the gaining set's population rises by one and the losing set's falls by one.
- R7: A store insert whose PC entry is valid writes its sequence number into its set's record and marks it valid; with an invalid entry the insert changes nothing.
- R8: A store issue clears its set's record only when the entry is valid, the record is valid, and the recorded sequence number equals the issuing one; any other issue changes nothing.
- R9: A squash with sequence number Q clears, in one cycle, every valid record whose sequence number is greater than or equal to Q and keeps the rest.
- R10: When violation, insert and issue arrive in the same cycle they take effect in that order: insert sees the sets just formed and issue sees the record just written.
- R11: A squash in a cycle blocks any violation, insert or issue presented in that same cycle.
- R12: The table index is PC bits [IDX_W+1:2] (IDX_W=6 by default); a new set number is that index of the store folded to SET_W bits, where set bit j is the XOR of every index bit i with i mod SET_W equal to j (so store index 0x13 forms set 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| viol_valid | input | 1 | A store/load ordering violation is reported |
| viol_store_pc | input | PC_W | PC of the violating store |
| viol_load_pc | input | PC_W | PC of the violating load |
| ins_valid | input | 1 | A store is being fetched |
| ins_pc | input | PC_W | PC of the fetched store |
| ins_seq | input | SEQ_W | Sequence number of the fetched store |
| chk_pc | input | PC_W | PC to look up |
| chk_tag | output | SEQ_W | Sequence number to wait for, 0 for none |
| iss_valid | input | 1 | A store is issuing |
| iss_pc | input | PC_W | PC of the issuing store |
| iss_seq | input | SEQ_W | Sequence number of the issuing store |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash point: records at or above it are dropped |

## Verification
The lookup is due in the same cycle as its PC, since it reads only registered state, while every violation, insert, issue and squash changes state at the next rising edge and becomes visible to the lookup only in the cycle after. The bench therefore drives all inputs on the falling edge, holds each state-changing operation for exactly one rising edge, and samples the tag one nanosecond after a following falling edge. Same-cycle combinations are driven together in one cycle and looked up in the next, so the order between them shows in the single tag that results.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    // How a violation resolves, chosen from the two entries' valid bits
    // and, when both are valid, from the set populations.
    typedef enum logic [2:0] {
        VK_IDLE,
        VK_FORM_NEW,
        VK_STORE_JOINS,
        VK_LOAD_JOINS,
        VK_STORE_MOVES,
        VK_LOAD_MOVES
    } viol_kind_e;

    // Gated operation enables for one cycle, after squash priority.
    typedef struct packed {
        logic viol;
        logic ins;
        logic iss;
        logic sq;
    } op_en_t;

endpackage

// File: rtl/ssp_id_table.sv
module ssp_id_table #(
    parameter int DEPTH = 64,
    parameter int SET_W = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        a_en,
    input  logic [$clog2(DEPTH)-1:0]    a_idx,
    input  logic [SET_W-1:0]            a_set,
    input  logic                        b_en,
    input  logic [$clog2(DEPTH)-1:0]    b_idx,
    input  logic [SET_W-1:0]            b_set,
    output logic [DEPTH-1:0]            vld_o,
    output logic [DEPTH-1:0][SET_W-1:0] set_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= '0;
            set_o <= '0;
        end else begin
            if (a_en) begin
                vld_o[a_idx] <= 1'b1;
                set_o[a_idx] <= a_set;
            end
            if (b_en) begin
                vld_o[b_idx] <= 1'b1;
                set_o[b_idx] <= b_set;
            end
        end
    end

endmodule

// File: rtl/ssp_viol_resolve.sv
module ssp_viol_resolve
    import ssp_pkg::*;
#(
    parameter int SET_W = 4,
    parameter int CNT_W = 7
) (
    input  logic             en,
    input  logic             ld_vld,
    input  logic [SET_W-1:0] ld_set,
    input  logic [CNT_W-1:0] ld_cnt,
    input  logic             st_vld,
    input  logic [SET_W-1:0] st_set,
    input  logic [CNT_W-1:0] st_cnt,
    input  logic [SET_W-1:0] new_set,
    output logic             ld_wr,
    output logic [SET_W-1:0] ld_wset,
    output logic             st_wr,
    output logic [SET_W-1:0] st_wset,
    output logic             inc_en,
    output logic [SET_W-1:0] inc_id,
    output logic             dec_en,
    output logic [SET_W-1:0] dec_id
);

    viol_kind_e kind;

    always_comb begin
        kind = VK_IDLE;
        if (en) begin
            unique case ({ld_vld, st_vld})
                2'b00: kind = VK_FORM_NEW;
                2'b10: kind = VK_STORE_JOINS;
                2'b01: kind = VK_LOAD_JOINS;
                default: kind = (ld_cnt > st_cnt) ? VK_STORE_MOVES : VK_LOAD_MOVES;
            endcase
        end
    end

    always_comb begin
        ld_wr   = 1'b0;
        ld_wset = st_set;
        st_wr   = 1'b0;
        st_wset = ld_set;
        inc_en  = 1'b0;
        inc_id  = ld_set;
        dec_en  = 1'b0;
        dec_id  = st_set;
        unique case (kind)
            VK_FORM_NEW: begin
                ld_wr   = 1'b1;
                ld_wset = new_set;
                st_wr   = 1'b1;
                st_wset = new_set;
                inc_en  = 1'b1;
                inc_id  = new_set;
            end
            VK_STORE_JOINS: begin
                st_wr  = 1'b1;
                inc_en = 1'b1;
            end
            VK_LOAD_JOINS: begin
                ld_wr = 1'b1;
            end
            VK_STORE_MOVES: begin
                st_wr  = 1'b1;
                inc_en = 1'b1;
                dec_en = 1'b1;
            end
            VK_LOAD_MOVES: begin
                ld_wr  = 1'b1;
                inc_en = 1'b1;
                inc_id = st_set;
                dec_en = 1'b1;
                dec_id = ld_set;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ssp_set_table.sv
module ssp_set_table #(
    parameter int SETS  = 16,
    parameter int SEQ_W = 16,
    parameter int CNT_W = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     inc_en,
    input  logic [$clog2(SETS)-1:0]  inc_id,
    input  logic                     dec_en,
    input  logic [$clog2(SETS)-1:0]  dec_id,
    input  logic                     ins_en,
    input  logic [$clog2(SETS)-1:0]  ins_id,
    input  logic [SEQ_W-1:0]         ins_seq,
    input  logic                     iss_en,
    input  logic [$clog2(SETS)-1:0]  iss_id,
    input  logic [SEQ_W-1:0]         iss_seq,
    input  logic                     sq_en,
    input  logic [SEQ_W-1:0]         sq_seq,
    input  logic [$clog2(SETS)-1:0]  rd_a_id,
    output logic [CNT_W-1:0]         cnt_a,
    input  logic [$clog2(SETS)-1:0]  rd_b_id,
    output logic [CNT_W-1:0]         cnt_b,
    input  logic [$clog2(SETS)-1:0]  chk_id,
    output logic                     chk_vld,
    output logic [SEQ_W-1:0]         chk_seq
);

    localparam int SET_W = $clog2(SETS);

    logic [SETS-1:0]            vld_all;
    logic [SETS-1:0][SEQ_W-1:0] seq_all;
    logic [SETS-1:0][CNT_W-1:0] cnt_all;

    for (genvar e = 0; e < SETS; e++) begin : g_set
        localparam logic [SET_W-1:0] MY_ID = SET_W'(e);
        logic             v_q, v_d;
        logic [SEQ_W-1:0] s_q, s_d;
        logic [CNT_W-1:0] c_q, c_d;

        always_comb begin
            c_d = c_q;
            v_d = v_q;
            s_d = s_q;
            if (sq_en) begin
                v_d = v_q && (s_q < sq_seq);
            end else begin
                if (inc_en && inc_id == MY_ID && c_d != '1) c_d = c_d + 1'b1;
                if (dec_en && dec_id == MY_ID && c_d != '0) c_d = c_d - 1'b1;
                if (ins_en && ins_id == MY_ID) begin
                    v_d = 1'b1;
                    s_d = ins_seq;
                end
                if (iss_en && iss_id == MY_ID && v_d && s_d == iss_seq) v_d = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                s_q <= '0;
                c_q <= '0;
            end else begin
                v_q <= v_d;
                s_q <= s_d;
                c_q <= c_d;
            end
        end

        assign vld_all[e] = v_q;
        assign seq_all[e] = s_q;
        assign cnt_all[e] = c_q;
    end

    assign cnt_a   = cnt_all[rd_a_id];
    assign cnt_b   = cnt_all[rd_b_id];
    assign chk_vld = vld_all[chk_id];
    assign chk_seq = seq_all[chk_id];

endmodule

// File: rtl/ssp_predictor.sv
module ssp_predictor
    import ssp_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int PC_LSB   = 2,
    parameter int ID_DEPTH = 64,
    parameter int SETS     = 16,
    parameter int SEQ_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             viol_valid,
    input  logic [PC_W-1:0]  viol_store_pc,
    input  logic [PC_W-1:0]  viol_load_pc,
    input  logic             ins_valid,
    input  logic [PC_W-1:0]  ins_pc,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic [PC_W-1:0]  chk_pc,
    output logic [SEQ_W-1:0] chk_tag,
    input  logic             iss_valid,
    input  logic [PC_W-1:0]  iss_pc,
    input  logic [SEQ_W-1:0] iss_seq,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq
);

    localparam int IDX_W = $clog2(ID_DEPTH);
    localparam int SET_W = $clog2(SETS);
    localparam int CNT_W = IDX_W + 1;
    localparam int HI    = PC_LSB + IDX_W;

    op_en_t en;

    logic [IDX_W-1:0] v_ld_idx, v_st_idx, ins_idx, iss_idx, chk_idx;
    logic [ID_DEPTH-1:0]            id_vld;
    logic [ID_DEPTH-1:0][SET_W-1:0] id_set;

    logic [SET_W-1:0] new_set;
    logic [CNT_W-1:0] ld_cnt, st_cnt;
    logic             ld_wr, st_wr, inc_en, dec_en;
    logic [SET_W-1:0] ld_wset, st_wset, inc_id, dec_id;

    logic             ins_hit, iss_hit, lfst_vld;
    logic [SET_W-1:0] ins_set, iss_set;
    logic [SEQ_W-1:0] lfst_seq;

    logic unused_pc_bits;
    assign unused_pc_bits = ^{viol_store_pc[PC_W-1:HI], viol_store_pc[PC_LSB-1:0],
                              viol_load_pc[PC_W-1:HI],  viol_load_pc[PC_LSB-1:0],
                              ins_pc[PC_W-1:HI],        ins_pc[PC_LSB-1:0],
                              iss_pc[PC_W-1:HI],        iss_pc[PC_LSB-1:0],
                              chk_pc[PC_W-1:HI],        chk_pc[PC_LSB-1:0]};

    assign v_ld_idx = viol_load_pc[PC_LSB +: IDX_W];
    assign v_st_idx = viol_store_pc[PC_LSB +: IDX_W];
    assign ins_idx  = ins_pc[PC_LSB +: IDX_W];
    assign iss_idx  = iss_pc[PC_LSB +: IDX_W];
    assign chk_idx  = chk_pc[PC_LSB +: IDX_W];

    // Fold the store's index down to a set number.
    always_comb begin
        new_set = '0;
        for (int i = 0; i < IDX_W; i++) begin
            new_set[i % SET_W] = new_set[i % SET_W] ^ v_st_idx[i];
        end
    end

    // Forward this cycle's violation writes to the insert and issue lookups.
    always_comb begin
        ins_hit = id_vld[ins_idx];
        ins_set = id_set[ins_idx];
        if (ld_wr && v_ld_idx == ins_idx) begin
            ins_hit = 1'b1;
            ins_set = ld_wset;
        end
        if (st_wr && v_st_idx == ins_idx) begin
            ins_hit = 1'b1;
            ins_set = st_wset;
        end
        iss_hit = id_vld[iss_idx];
        iss_set = id_set[iss_idx];
        if (ld_wr && v_ld_idx == iss_idx) begin
            iss_hit = 1'b1;
            iss_set = ld_wset;
        end
        if (st_wr && v_st_idx == iss_idx) begin
            iss_hit = 1'b1;
            iss_set = st_wset;
        end
    end

    always_comb begin
        en.sq   = sq_valid;
        en.viol = viol_valid && !sq_valid;
        en.ins  = ins_valid && !sq_valid && ins_hit;
        en.iss  = iss_valid && !sq_valid && iss_hit;
    end

    ssp_viol_resolve #(.SET_W(SET_W), .CNT_W(CNT_W)) u_resolve (
        .en      (en.viol),
        .ld_vld  (id_vld[v_ld_idx]),
        .ld_set  (id_set[v_ld_idx]),
        .ld_cnt  (ld_cnt),
        .st_vld  (id_vld[v_st_idx]),
        .st_set  (id_set[v_st_idx]),
        .st_cnt  (st_cnt),
        .new_set (new_set),
        .ld_wr   (ld_wr),
        .ld_wset (ld_wset),
        .st_wr   (st_wr),
        .st_wset (st_wset),
        .inc_en  (inc_en),
        .inc_id  (inc_id),
        .dec_en  (dec_en),
        .dec_id  (dec_id)
    );

    ssp_id_table #(.DEPTH(ID_DEPTH), .SET_W(SET_W)) u_ids (
        .clk   (clk),
        .rst   (rst),
        .a_en  (ld_wr),
        .a_idx (v_ld_idx),
        .a_set (ld_wset),
        .b_en  (st_wr),
        .b_idx (v_st_idx),
        .b_set (st_wset),
        .vld_o (id_vld),
        .set_o (id_set)
    );

    ssp_set_table #(.SETS(SETS), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_sets (
        .clk     (clk),
        .rst     (rst),
        .inc_en  (inc_en),
        .inc_id  (inc_id),
        .dec_en  (dec_en),
        .dec_id  (dec_id),
        .ins_en  (en.ins),
        .ins_id  (ins_set),
        .ins_seq (ins_seq),
        .iss_en  (en.iss),
        .iss_id  (iss_set),
        .iss_seq (iss_seq),
        .sq_en   (en.sq),
        .sq_seq  (sq_seq),
        .rd_a_id (id_set[v_ld_idx]),
        .cnt_a   (ld_cnt),
        .rd_b_id (id_set[v_st_idx]),
        .cnt_b   (st_cnt),
        .chk_id  (id_set[chk_idx]),
        .chk_vld (lfst_vld),
        .chk_seq (lfst_seq)
    );

    assign chk_tag = (id_vld[chk_idx] && lfst_vld) ? lfst_seq : '0;

endmodule

// File: rtl/ssp_predictor_chk.sv
module ssp_predictor_chk #(
    parameter int PC_W     = 32,
    parameter int ID_DEPTH = 64,
    parameter int SET_W    = 4,
    parameter int SEQ_W    = 16
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           viol_valid,
    input logic                           ins_valid,
    input logic                           iss_valid,
    input logic                           sq_valid,
    input logic [PC_W-1:0]                ins_pc,
    input logic [PC_W-1:0]                iss_pc,
    input logic [PC_W-1:0]                chk_pc,
    input logic [SEQ_W-1:0]               ins_seq,
    input logic [SEQ_W-1:0]               iss_seq,
    input logic [SEQ_W-1:0]               sq_seq,
    input logic [SEQ_W-1:0]               chk_tag,
    input logic [$clog2(ID_DEPTH)-1:0]    v_ld_idx,
    input logic [$clog2(ID_DEPTH)-1:0]    v_st_idx,
    input logic [$clog2(ID_DEPTH)-1:0]    chk_idx,
    input logic [ID_DEPTH-1:0]            id_vld,
    input logic [ID_DEPTH-1:0][SET_W-1:0] id_set
);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> chk_tag == '0); // R1

    AST_TAG_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        chk_tag != '0 |-> id_vld[chk_idx]); // R2

    AST_VIOL_SHARES_SET: assert property (@(posedge clk) disable iff (rst)
        (viol_valid && !sq_valid) |=>
        (id_vld[$past(v_ld_idx)] && id_vld[$past(v_st_idx)] &&
         id_set[$past(v_ld_idx)] == id_set[$past(v_st_idx)])); // R3

    AST_INSERT_RECORDS: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !sq_valid && !iss_valid && chk_pc == ins_pc) |=>
        (!$stable(chk_pc) || chk_tag == '0 || chk_tag == $past(ins_seq))); // R7

    AST_ISSUE_RETIRES: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !sq_valid && !viol_valid && !ins_valid &&
         chk_pc == iss_pc && iss_seq != '0 && chk_tag == iss_seq) |=>
        (!$stable(chk_pc) || chk_tag == '0)); // R8

    AST_SQUASH_SWEEP: assert property (@(posedge clk) disable iff (rst)
        sq_valid |=> (chk_tag == '0 || chk_tag < $past(sq_seq))); // R9

endmodule

bind ssp_predictor ssp_predictor_chk #(
    .PC_W(PC_W), .ID_DEPTH(ID_DEPTH), .SET_W(SET_W), .SEQ_W(SEQ_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .viol_valid (viol_valid),
    .ins_valid  (ins_valid),
    .iss_valid  (iss_valid),
    .sq_valid   (sq_valid),
    .ins_pc     (ins_pc),
    .iss_pc     (iss_pc),
    .chk_pc     (chk_pc),
    .ins_seq    (ins_seq),
    .iss_seq    (iss_seq),
    .sq_seq     (sq_seq),
    .chk_tag    (chk_tag),
    .v_ld_idx   (v_ld_idx),
    .v_st_idx   (v_st_idx),
    .chk_idx    (chk_idx),
    .id_vld     (id_vld),
    .id_set     (id_set)
);

// File: tb/sim_ssp_predictor.sv
module sim_ssp_predictor;

    localparam int PC_W  = 32;
    localparam int SEQ_W = 16;

    localparam logic [2:0] OP_CHK  = 3'd0;
    localparam logic [2:0] OP_VIOL = 3'd1;
    localparam logic [2:0] OP_INS  = 3'd2;
    localparam logic [2:0] OP_ISS  = 3'd3;
    localparam logic [2:0] OP_SQ   = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;    // store PC, insert/issue/check PC
        logic [31:0] b;    // load PC for violations
        logic [15:0] seq;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    // PCs: index = PC/4. L1=04 S1=08 S2=0C L2=10 S3=14 L3=18
    //      S4=1C L4=20 S5=24 L5=28
    localparam int NV = 42;
    localparam vec_t VECS [NV] = '{
        '{OP_CHK,  32'h04, 32'h00, 16'd0,  16'd0,  8'd1},  // R1 empty after reset
        '{OP_INS,  32'h08, 32'h00, 16'd5,  16'd0,  8'd7},
        '{OP_CHK,  32'h08, 32'h00, 16'd0,  16'd0,  8'd7},  // R7 insert without entry ignored
        '{OP_VIOL, 32'h08, 32'h04, 16'd0,  16'd0,  8'd3},  // R3 forms set 2
        '{OP_CHK,  32'h04, 32'h00, 16'd0,  16'd0,  8'd2},  // R2 entry valid, record not
        '{OP_INS,  32'h08, 32'h00, 16'd7,  16'd0,  8'd7},
        '{OP_CHK,  32'h04, 32'h00, 16'd0,  16'd7,  8'd3},  // R3 load sees store
        '{OP_CHK,  32'h08, 32'h00, 16'd0,  16'd7,  8'd3},
        '{OP_ISS,  32'h08, 32'h00, 16'd6,  16'd0,  8'd8},
        '{OP_CHK,  32'h04, 32'h00, 16'd0,  16'd7,  8'd8},  // R8 mismatched issue ignored
        '{OP_ISS,  32'h08, 32'h00, 16'd7,  16'd0,  8'd8},
        '{OP_CHK,  32'h04, 32'h00, 16'd0,  16'd0,  8'd8},  // R8 matching issue clears
        '{OP_VIOL, 32'h0C, 32'h04, 16'd0,  16'd0,  8'd4},  // R4 S2 joins set 2
        '{OP_INS,  32'h0C, 32'h00, 16'd9,  16'd0,  8'd4},
        '{OP_CHK,  32'h04, 32'h00, 16'd0,  16'd9,  8'd4},
        '{OP_VIOL, 32'h08, 32'h10, 16'd0,  16'd0,  8'd5},  // R5 L2 joins set 2
        '{OP_CHK,  32'h10, 32'h00, 16'd0,  16'd9,  8'd5},
        '{OP_VIOL, 32'h14, 32'h18, 16'd0,  16'd0,  8'd3},  // R3 forms set 5
        '{OP_INS,  32'h14, 32'h00, 16'd20, 16'd0,  8'd3},
        '{OP_CHK,  32'h18, 32'h00, 16'd0,  16'd20, 8'd12}, // R12 distinct set
        '{OP_VIOL, 32'h14, 32'h04, 16'd0,  16'd0,  8'd6},  // R6 load set larger, S3 moves
        '{OP_INS,  32'h14, 32'h00, 16'd21, 16'd0,  8'd6},
        '{OP_CHK,  32'h04, 32'h00, 16'd0,  16'd21, 8'd6},
        '{OP_CHK,  32'h18, 32'h00, 16'd0,  16'd20, 8'd6},
        '{OP_VIOL, 32'h1C, 32'h20, 16'd0,  16'd0,  8'd3},  // set 7
        '{OP_VIOL, 32'h24, 32'h28, 16'd0,  16'd0,  8'd3},  // set 9
        '{OP_VIOL, 32'h1C, 32'h28, 16'd0,  16'd0,  8'd6},  // R6 tie, L5 moves to 7
        '{OP_INS,  32'h1C, 32'h00, 16'd30, 16'd0,  8'd6},
        '{OP_CHK,  32'h28, 32'h00, 16'd0,  16'd30, 8'd6},
        '{OP_INS,  32'h24, 32'h00, 16'd31, 16'd0,  8'd6},
        '{OP_CHK,  32'h28, 32'h00, 16'd0,  16'd30, 8'd6},  // R6 tie direction
        '{OP_CHK,  32'h20, 32'h00, 16'd0,  16'd30, 8'd6},
        '{OP_VIOL, 32'h24, 32'h20, 16'd0,  16'd0,  8'd6},  // R6 S5 moves to 7
        '{OP_INS,  32'h24, 32'h00, 16'd33, 16'd0,  8'd6},
        '{OP_CHK,  32'h20, 32'h00, 16'd0,  16'd33, 8'd6},
        '{OP_SQ,   32'h00, 32'h00, 16'd25, 16'd0,  8'd9},  // R9 drops 33 and 31
        '{OP_CHK,  32'h20, 32'h00, 16'd0,  16'd0,  8'd9},
        '{OP_CHK,  32'h18, 32'h00, 16'd0,  16'd20, 8'd9},
        '{OP_CHK,  32'h04, 32'h00, 16'd0,  16'd21, 8'd9},
        '{OP_SQ,   32'h00, 32'h00, 16'd21, 16'd0,  8'd9},  // R9 equal is dropped
        '{OP_CHK,  32'h04, 32'h00, 16'd0,  16'd0,  8'd9},
        '{OP_CHK,  32'h18, 32'h00, 16'd0,  16'd20, 8'd9}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             viol_valid = 1'b0;
    logic [PC_W-1:0]  viol_store_pc = '0;
    logic [PC_W-1:0]  viol_load_pc = '0;
    logic             ins_valid = 1'b0;
    logic [PC_W-1:0]  ins_pc = '0;
    logic [SEQ_W-1:0] ins_seq = '0;
    logic [PC_W-1:0]  chk_pc = '0;
    logic [SEQ_W-1:0] chk_tag;
    logic             iss_valid = 1'b0;
    logic [PC_W-1:0]  iss_pc = '0;
    logic [SEQ_W-1:0] iss_seq = '0;
    logic             sq_valid = 1'b0;
    logic [SEQ_W-1:0] sq_seq = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ssp_predictor u0 (
        .clk(clk), .rst(rst),
        .viol_valid(viol_valid), .viol_store_pc(viol_store_pc), .viol_load_pc(viol_load_pc),
        .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_seq(ins_seq),
        .chk_pc(chk_pc), .chk_tag(chk_tag),
        .iss_valid(iss_valid), .iss_pc(iss_pc), .iss_seq(iss_seq),
        .sq_valid(sq_valid), .sq_seq(sq_seq)
    );

    task automatic next_cycle();
        @(negedge clk);
        viol_valid = 1'b0;
        ins_valid  = 1'b0;
        iss_valid  = 1'b0;
        sq_valid   = 1'b0;
    endtask

    task automatic check_tag(input logic [31:0] pc, input logic [15:0] exp, input string req);
        chk_pc = pc;
        #1;
        total++;
        if (chk_tag !== exp) begin
            bad++;
            $display("FAIL %s pc=%h actual=%0d expected=%0d", req, pc, chk_tag, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            next_cycle();
            case (VECS[i].op)
                OP_CHK:  check_tag(VECS[i].a, VECS[i].exp, $sformatf("R%0d", VECS[i].req));
                OP_VIOL: begin
                    viol_valid = 1'b1; viol_store_pc = VECS[i].a; viol_load_pc = VECS[i].b;
                end
                OP_INS:  begin ins_valid = 1'b1; ins_pc = VECS[i].a; ins_seq = VECS[i].seq; end
                OP_ISS:  begin iss_valid = 1'b1; iss_pc = VECS[i].a; iss_seq = VECS[i].seq; end
                default: begin sq_valid = 1'b1; sq_seq = VECS[i].seq; end
            endcase
        end

        // R12: store index 0x13 folds to set 2, shared with L1 (pc 0x04)
        next_cycle();
        viol_valid = 1'b1; viol_store_pc = 32'h4C; viol_load_pc = 32'h50;
        next_cycle();
        ins_valid = 1'b1; ins_pc = 32'h4C; ins_seq = 16'd45;
        next_cycle();
        check_tag(32'h04, 16'd45, "R12");

        // R10: violation and insert in one cycle, insert uses the new set
        next_cycle();
        viol_valid = 1'b1; viol_store_pc = 32'h2C; viol_load_pc = 32'h30;
        ins_valid = 1'b1; ins_pc = 32'h2C; ins_seq = 16'd40;
        next_cycle();
        check_tag(32'h30, 16'd40, "R10");

        // R10: insert then issue of the same sequence number in one cycle
        next_cycle();
        ins_valid = 1'b1; ins_pc = 32'h2C; ins_seq = 16'd41;
        iss_valid = 1'b1; iss_pc = 32'h2C; iss_seq = 16'd41;
        next_cycle();
        check_tag(32'h30, 16'd0, "R10");

        // R11: squash blocks an insert in its cycle
        next_cycle();
        ins_valid = 1'b1; ins_pc = 32'h2C; ins_seq = 16'd50;
        sq_valid = 1'b1; sq_seq = 16'd60;
        next_cycle();
        check_tag(32'h30, 16'd0, "R11");

        // R11: squash blocks a violation in its cycle
        next_cycle();
        viol_valid = 1'b1; viol_store_pc = 32'h34; viol_load_pc = 32'h38;
        sq_valid = 1'b1; sq_seq = 16'd60;
        next_cycle();
        ins_valid = 1'b1; ins_pc = 32'h34; ins_seq = 16'd55;
        next_cycle();
        check_tag(32'h38, 16'd0, "R11");

        // R1: mid-run reset forgets every set
        next_cycle();
        ins_valid = 1'b1; ins_pc = 32'h14; ins_seq = 16'd70;
        next_cycle();
        check_tag(32'h04, 16'd70, "R1");
        rst = 1'b1;
        next_cycle();
        next_cycle();
        rst = 1'b0;
        check_tag(32'h04, 16'd0, "R1");
        next_cycle();
        ins_valid = 1'b1; ins_pc = 32'h14; ins_seq = 16'd71;
        next_cycle();
        check_tag(32'h04, 16'd0, "R1");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule